// File: doc/BRIEF.md
# Extended Parallel-Port Mode Register Bank with Test FIFO

This block is the second register window of a parallel-port controller that supports extended transfer modes. It offers three live byte locations: a data location at offset 0, a configuration byte at offset 1 and a mode-and-status register at offset 2. Offsets 3 to 7 are unused. The mode register holds a 3-bit operating mode in bits 7:5 and reports the state of a small byte FIFO in bits 1:0.

When the mode field selects FIFO test (code 6), offset 0 becomes the FIFO port. A write pushes a byte and a read pops one. In every other mode, offset 0 is a plain byte register and the FIFO is left alone. Any write that changes the mode field empties the FIFO. Software uses this to check the FIFO path before it hands the queue to a transfer engine, which is not part of this block.

The host side is a simple single-cycle register bus. Each access is one cycle with `wr_en` or `rd_en` high, and the two strobes are never high together. Read data is registered: it appears on `rdata` after the clock edge that samples the read strobe, and it holds until the next read.

Top module: `ecp_ext_regs`

## Requirements
- R1: After reset, offset 2 reads 0x01 (compatible mode 0, FIFO empty), and offsets 0 and 1 read 0x00.
- R2: A write to offset 2 sets the mode to written bits 7:5. Written bits 4:0 are ignored. Offset 2 always reads {mode, 3'b000, full, empty}, so bit 1 is the full flag and bit 0 is the empty flag (01 empty, 10 full, 00 partly filled).
- R3: A write to offset 2 whose mode field differs from the current mode empties the FIFO and discards its contents. Offset 2 then reads with status bits 01.
- R4: A write to offset 2 that repeats the current mode leaves the FIFO contents and flags unchanged.
- R5: In FIFO-test mode (6), a write to offset 0 pushes the byte. The status reads 00 while the FIFO is partly filled and 10 once it holds DEPTH bytes (default 2).
- R6: In FIFO-test mode, a read of offset 0 returns the oldest byte and removes it. The status reads 01 once the last byte is removed and 00 otherwise.
- R7: A push while the FIFO is full is ignored. The stored bytes and the full status are unchanged.
- R8: A pop while the FIFO is empty returns the byte most recently popped (0x00 if none since reset) and leaves the status at empty.
- R9: Outside FIFO-test mode, offset 0 is a plain read/write byte register. Accesses to it do not change the FIFO contents or flags.
- R10: Offset 1 is a plain read/write byte register.
- R11: Reads of offsets 3 to 7 return 0xFF. Writes to them change no readable state.
- R12: Read data appears on `rdata` one clock after the cycle with `rd_en` high, and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 3 | Byte offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The FIFO state is visible only through the two status bits and the bytes that pops return. A wrong count or pointer shows up at the next read of offset 2 as a wrong flag code, or at the next pop as a byte out of order or a stale byte. A missed or spurious flush shows up when the next status read after a mode write disagrees with the expected 01 or retained code. A fault in plain-register decode is caught when the same offset is read back, one clock after the read strobe.

// File: rtl/ecp_pkg.sv
// Shared definitions for the extended parallel-port register window.
// Assumes a 3-bit byte offset and byte-wide data.
package ecp_pkg;
    typedef enum logic [2:0] {
        MODE_COMPAT  = 3'd0,
        MODE_BYTE    = 3'd1,
        MODE_PPFIFO  = 3'd2,
        MODE_ECPFIFO = 3'd3,
        MODE_EPP     = 3'd4,
        MODE_RSVD    = 3'd5,
        MODE_TEST    = 3'd6,
        MODE_CONFIG  = 3'd7
    } ecp_mode_e;

    localparam int          OFS_W       = 3;
    localparam logic [2:0]  OFS_DATA    = 3'd0;
    localparam logic [2:0]  OFS_CFGB    = 3'd1;
    localparam logic [2:0]  OFS_MODE    = 3'd2;
    localparam logic [7:0]  UNUSED_BYTE = 8'hFF;
endpackage

// File: rtl/ecp_byte_fifo.sv
// Small circular byte queue with a flush input and an occupancy counter.
// Push when full and pop when empty are dropped. Flush takes priority.
// Assumes push and pop are never requested in the same cycle.
module ecp_byte_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          take_push, take_pop;

    // Accept requests only when they can be served
    always_comb begin
        take_push = push && (count != FULL_CNT) && !flush;
        take_pop  = pop && (count != '0) && !flush;
    end

    // One storage byte per entry, loaded when the write pointer selects it
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[i] <= '0;
            else if (take_push && (wptr == PW'(i)))
                slot[i] <= din;
        end
    end

    // Pointer and occupancy bookkeeping, with wrap at the last entry
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (take_push) begin
                wptr  <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
                count <= count + 1'b1;
            end
            if (take_pop) begin
                rptr  <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
                count <= count - 1'b1;
            end
        end
    end

    assign dout  = slot[rptr];
    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    a_r7_full_push_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !flush) |=> (full && $stable(rptr)));
    a_r8_empty_pop_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> empty);
    a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !full));
    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));
endmodule

// File: rtl/ecp_cfg_regs.sv
// Mode field, configuration byte and plain data byte of the window.
// Raises flush in the cycle of a mode write that changes the mode.
// Assumes one access per cycle.
module ecp_cfg_regs
    import ecp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] addr,
    input  logic [W-1:0]     wdata,
    output ecp_mode_e        mode,
    output logic [W-1:0]     cfgb,
    output logic [W-1:0]     plain,
    output logic             flush
);
    ecp_mode_e new_mode;

    // Decode the requested mode and detect an actual change
    always_comb begin
        new_mode = ecp_mode_e'(wdata[W-1 -: 3]);
        flush    = wr_en && (addr == OFS_MODE) && (new_mode != mode);
    end

    // Register updates for the three writable locations
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= MODE_COMPAT;
            cfgb  <= '0;
            plain <= '0;
        end else if (wr_en) begin
            if (addr == OFS_MODE)
                mode <= new_mode;
            if (addr == OFS_CFGB)
                cfgb <= wdata;
            if ((addr == OFS_DATA) && (mode != MODE_TEST))
                plain <= wdata;
        end
    end

    a_r4_flush_only_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (mode != $past(mode)));
    a_r10_cfgb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFS_CFGB) |=> $stable(cfgb));
endmodule

// File: rtl/ecp_ext_regs.sv
// Top of the extended register window. Routes offset 0 to the FIFO in
// test mode, builds the mode/status byte and registers the read data.
// Assumes wr_en and rd_en are never high in the same cycle.
module ecp_ext_regs
    import ecp_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFS_W-1:0] addr,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata
);
    ecp_mode_e    mode;
    logic [W-1:0] cfgb, plain, fifo_out, last_pop, status_byte;
    logic         flush, push, pop, empty, full, fifo_port;

    ecp_cfg_regs #(.W(W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .mode(mode), .cfgb(cfgb), .plain(plain), .flush(flush)
    );

    ecp_byte_fifo #(.DEPTH(DEPTH), .W(W)) i_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
        .din(wdata), .dout(fifo_out), .empty(empty), .full(full)
    );

    // Steer offset-0 accesses to the FIFO when in test mode
    always_comb begin
        fifo_port   = (addr == OFS_DATA) && (mode == MODE_TEST);
        push        = wr_en && fifo_port;
        pop         = rd_en && fifo_port;
        status_byte = {mode, {(W-5){1'b0}}, full, empty};
    end

    // Registered read data and the byte most recently popped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            last_pop <= '0;
        end else if (rd_en) begin
            case (addr)
                OFS_DATA: begin
                    if (mode != MODE_TEST)
                        rdata <= plain;
                    else if (!empty) begin
                        rdata    <= fifo_out;
                        last_pop <= fifo_out;
                    end else
                        rdata <= last_pop;
                end
                OFS_CFGB: rdata <= cfgb;
                OFS_MODE: rdata <= status_byte;
                default:  rdata <= UNUSED_BYTE;
            endcase
        end
    end

    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    a_r8_empty_pop_stale: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> (rdata == $past(last_pop)));
    a_r9_plain_no_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DATA && mode != MODE_TEST) |=> ($stable(empty) && $stable(full)));
endmodule

// File: tb/test_ecp_ext_regs.sv
module test_ecp_ext_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int compared = 0, mismatched = 0, cycles = 0;
    bit finished = 0;

    logic [2:0] m_mode = 3'd0;
    logic [7:0] m_mem [2];
    int         m_cnt = 0, m_rp = 0, m_wp = 0;
    logic [7:0] m_last = 8'h00, m_plain = 8'h00, m_cfgb = 8'h00;

    ecp_ext_regs i_ecp_ext_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    function automatic string tag_of(input logic [2:0] a);
        if (a == 3'd0) return (m_mode == 3'd6) ? "R6" : "R9";
        if (a == 3'd1) return "R10";
        if (a == 3'd2) return "R2";
        return "R11";
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            3'd0: if (m_mode == 3'd6) begin
                      if (m_cnt < 2) begin
                          m_mem[m_wp] = d; m_wp = (m_wp + 1) % 2; m_cnt++;
                      end
                  end else m_plain = d;
            3'd1: m_cfgb = d;
            3'd2: begin
                      if (d[7:5] != m_mode) begin m_cnt = 0; m_rp = 0; m_wp = 0; end
                      m_mode = d[7:5];
                  end
            default: ;
        endcase
    endtask

    task automatic do_rd(input logic [2:0] a, input string req);
        logic [7:0] exp;
        string t;
        t = (req == "") ? tag_of(a) : req;
        case (a)
            3'd0: if (m_mode == 3'd6) begin
                      if (m_cnt > 0) begin
                          exp = m_mem[m_rp]; m_last = exp; m_rp = (m_rp + 1) % 2; m_cnt--;
                      end else exp = m_last;
                  end else exp = m_plain;
            3'd1: exp = m_cfgb;
            3'd2: exp = {m_mode, 3'b000, m_cnt == 2, m_cnt == 0};
            default: exp = 8'hFF;
        endcase
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(t, rdata, exp);
    endtask

    initial begin
        logic [7:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        do_rd(3'd2, "R1");
        do_rd(3'd1, "R1");
        do_rd(3'd0, "R1");
        do_wr(3'd1, 8'hA5); do_rd(3'd1, "R10");
        do_wr(3'd0, 8'h3C); do_rd(3'd0, "R9");
        do_wr(3'd2, 8'hDF); do_rd(3'd2, "R2");
        do_wr(3'd0, 8'h11); do_rd(3'd2, "R5");
        do_wr(3'd0, 8'h22); do_rd(3'd2, "R5");
        do_wr(3'd0, 8'h33); do_rd(3'd2, "R7");
        do_rd(3'd0, "R6");  do_rd(3'd2, "R6");
        do_rd(3'd0, "R7");  do_rd(3'd2, "R6");
        do_rd(3'd0, "R8");  do_rd(3'd2, "R8");
        do_wr(3'd0, 8'h44);
        do_wr(3'd2, 8'hC0); do_rd(3'd2, "R4");
        do_rd(3'd0, "R4");
        do_wr(3'd0, 8'h55);
        do_wr(3'd2, 8'h00); do_rd(3'd2, "R3");
        do_wr(3'd0, 8'h77); do_rd(3'd0, "R9");
        do_wr(3'd2, 8'hC0); do_rd(3'd2, "R3");
        do_wr(3'd5, 8'h00); do_rd(3'd5, "R11");
        do_rd(3'd3, "R11"); do_rd(3'd7, "R11");
        do_rd(3'd1, "R11");
        held = rdata;
        repeat (5) @(negedge clk);
        check("R12", rdata, held);
        for (int n = 0; n < 600; n++) begin
            int sel;
            logic [2:0] a;
            sel = $urandom % 16;
            a = 3'($urandom % 8);
            if (sel == 0) begin
                logic [7:0] d;
                d = 8'($urandom);
                if ($urandom % 2 == 0) d[7:5] = 3'd6;
                do_wr(3'd2, d);
            end else if (sel < 6) do_wr(3'd0, 8'($urandom));
            else if (sel < 11) do_rd(3'd0, "");
            else if (sel < 13) do_wr(a, 8'($urandom));
            else do_rd(a, "");
        end
        do_rd(3'd2, "R2");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule